// File: doc/BRIEF.md
# Branch Hazard Control Unit

This block steers the front of a five-stage in-order pipeline around control hazards. Branches and jumps are fetched in the first stage but only resolve in the third, so the right next fetch address is known two cycles after fetch. Each cycle the unit reads the resolution from the execute stage and a valid flag for each early stage. It then drives the PC write enable, the next-PC select (sequential or branch target), squash controls for the IF/ID and ID/EX pipeline registers, and a hold for IF/ID that is driven by a data-hazard stall request.

A static two-bit policy input picks one of three ways to handle a control hazard. In delay-slot mode the single instruction after a branch always completes. In stall-and-zap mode fetch is frozen behind an unresolved branch and the fetched instruction is turned into a bubble. In speculative mode the pipeline assumes the branch is not taken and flushes the wrong path on a taken outcome. For observation, the unit reports how many control squashes it issued this cycle. On each resolution it also reports the total number of bubbles that branch cost, including any inserted a cycle earlier.

Top module: `bhc_ctrl`

## Requirements
- R1: While `rst` is high, `pc_we`, `pc_sel`, `ifid_squash`, `idex_squash`, `ifid_hold`, `flush_count`, `res_valid` and `res_bubbles` are all 0, and `pc_sel` = 0 means PC+4.
- R2: Policy encoding: 0 selects delay slot, 1 selects stall-and-zap, 2 and 3 both select predict-not-taken speculation.
- R3: A taken control instruction in EX (`ex_valid & ex_is_ctrl & ex_taken`) drives `pc_sel` = 1 (target) and `pc_we` = 1 in that same cycle under every policy; otherwise `pc_sel` = 0.
- R4: In delay-slot mode a taken branch squashes IF/ID when `if_valid` is set, and control never squashes ID/EX, so the slot instruction in ID always proceeds.
- R5: In stall-and-zap mode a valid control instruction in ID holds the PC (`pc_we` = 0 unless a redirect occurs). It also squashes IF/ID when `if_valid` is set and there is no data stall, so the branch moves into EX.
- R6: In speculative mode a taken branch in EX squashes IF/ID (if `if_valid`) and ID/EX (if `id_valid`) in the same cycle. A not-taken branch squashes nothing.
- R7: A control squash beats a data stall: `ifid_hold` = `data_stall` and not `ifid_squash`. `pc_we` = redirect or (no data stall and no stall-and-zap hold). A data stall always asserts `idex_squash`.
- R8: `flush_count` equals the number of control-caused squashes this cycle (IF/ID and ID/EX), 0 to 2; squashes caused by a data stall are not counted.
- R9: `res_valid` is high exactly when a valid control instruction is in EX. `res_bubbles` is then `flush_count` plus 1 if the previous cycle issued a stall-and-zap IF/ID squash, else 0.
- R10: In a normal instruction stream a branch costs delay slot 1 / 0, stall-and-zap 2 / 1, and speculative 2 / 0 bubbles (taken / not taken), as reported on `res_bubbles`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | Control-hazard policy select |
| if_valid | input | 1 | IF stage holds a valid instruction |
| id_valid | input | 1 | ID stage holds a valid instruction |
| ex_valid | input | 1 | EX stage holds a valid instruction |
| id_is_ctrl | input | 1 | Instruction in ID is a branch or jump |
| ex_is_ctrl | input | 1 | Instruction in EX is a branch or jump |
| ex_taken | input | 1 | Resolved outcome of the EX control instruction |
| data_stall | input | 1 | Data-hazard stall request for IF and ID |
| pc_we | output | 1 | PC write enable |
| pc_sel | output | 1 | Next PC: 0 = PC+4, 1 = branch target |
| ifid_squash | output | 1 | Turn the IF/ID register into a bubble |
| ifid_hold | output | 1 | Keep the IF/ID register contents |
| idex_squash | output | 1 | Turn the ID/EX register into a bubble |
| flush_count | output | 2 | Control squashes issued this cycle |
| res_valid | output | 1 | A branch resolves this cycle |
| res_bubbles | output | 2 | Total bubbles charged to the resolving branch |

## Verification
The hardest situation to reach is the two-cycle stall-and-zap cost. One squash is issued while the branch sits in ID and the other when it resolves in EX, so the reported total depends on what happened in the cycle before. The sweep applies every combination of policy, valid flags, control flags, outcome and data stall, one per cycle. This means each vector also follows a different predecessor, and the bench carries the expected pending bubble forward from the previous vector. Short scripted two-cycle streams then place a branch in ID and next in EX under each policy and outcome, and compare the per-branch cost.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
  localparam int POL_W = 2;
  localparam int CNT_W = 2;
  localparam int NSQ   = 2;

  typedef enum logic [POL_W-1:0] {
    POL_DELAY    = 2'd0,
    POL_STALL    = 2'd1,
    POL_SPEC     = 2'd2,
    POL_SPEC_ALT = 2'd3
  } policy_e;

  typedef enum logic {
    NPC_SEQ    = 1'b0,
    NPC_TARGET = 1'b1
  } npc_e;

  // bit order matters: popcount over the packed vector
  typedef struct packed {
    logic idex;
    logic ifid;
  } squash_t;
endpackage

// File: rtl/bhc_resolve.sv
module bhc_resolve (
  input  logic ex_valid,
  input  logic ex_is_ctrl,
  input  logic ex_taken,
  output logic resolve,
  output logic redirect
);
  always_comb begin
    resolve  = ex_valid & ex_is_ctrl;
    redirect = resolve & ex_taken;
  end
endmodule

// File: rtl/bhc_squash.sv
module bhc_squash
  import bhc_pkg::*;
(
  input  logic [POL_W-1:0] policy,
  input  logic             if_valid,
  input  logic             id_valid,
  input  logic             id_is_ctrl,
  input  logic             data_stall,
  input  logic             redirect,
  output squash_t          ctl,
  output logic             id_hold,
  output logic             id_zap
);
  policy_e pol;

  always_comb begin
    pol     = policy_e'(policy);
    ctl     = '0;
    id_hold = 1'b0;
    id_zap  = 1'b0;
    unique case (pol)
      POL_DELAY: begin
        // slot instruction in ID survives; only the one behind it dies
        ctl.ifid = if_valid & redirect;
      end
      POL_STALL: begin
        id_hold  = id_valid & id_is_ctrl;
        id_zap   = id_hold & ~data_stall & if_valid;
        ctl.ifid = (if_valid & redirect) | id_zap;
      end
      default: begin
        ctl.ifid = if_valid & redirect;
        ctl.idex = id_valid & redirect;
      end
    endcase
  end
endmodule

// File: rtl/bhc_tally.sv
module bhc_tally #(
  parameter int N  = 2,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  squash_vec,
  input  logic          resolve,
  input  logic          id_zap,
  output logic [CW-1:0] flush_count,
  output logic [CW-1:0] res_bubbles
);
  logic pend_q;

  always_comb begin
    flush_count = '0;
    for (int i = 0; i < N; i++) begin
      flush_count = flush_count + CW'(squash_vec[i]);
    end
    res_bubbles = resolve ? (flush_count + CW'(pend_q)) : '0;
  end

  // a branch zapped in ID is always in EX on the next cycle
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= id_zap;
  end
endmodule

// File: rtl/bhc_ctrl.sv
module bhc_ctrl
  import bhc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [POL_W-1:0] policy,
  input  logic             if_valid,
  input  logic             id_valid,
  input  logic             ex_valid,
  input  logic             id_is_ctrl,
  input  logic             ex_is_ctrl,
  input  logic             ex_taken,
  input  logic             data_stall,
  output logic             pc_we,
  output logic             pc_sel,
  output logic             ifid_squash,
  output logic             ifid_hold,
  output logic             idex_squash,
  output logic [CNT_W-1:0] flush_count,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_bubbles
);
  logic             resolve;
  logic             redirect;
  squash_t          ctl;
  logic             id_hold;
  logic             id_zap;
  logic [CNT_W-1:0] fc;
  logic [CNT_W-1:0] rb;
  npc_e             npc;

  bhc_resolve u_res (
    .ex_valid   (ex_valid),
    .ex_is_ctrl (ex_is_ctrl),
    .ex_taken   (ex_taken),
    .resolve    (resolve),
    .redirect   (redirect)
  );

  bhc_squash u_sq (
    .policy     (policy),
    .if_valid   (if_valid),
    .id_valid   (id_valid),
    .id_is_ctrl (id_is_ctrl),
    .data_stall (data_stall),
    .redirect   (redirect),
    .ctl        (ctl),
    .id_hold    (id_hold),
    .id_zap     (id_zap)
  );

  bhc_tally #(.N(NSQ), .CW(CNT_W)) u_tal (
    .clk         (clk),
    .rst         (rst),
    .squash_vec  (ctl),
    .resolve     (resolve),
    .id_zap      (id_zap),
    .flush_count (fc),
    .res_bubbles (rb)
  );

  always_comb begin
    npc         = (~rst & redirect) ? NPC_TARGET : NPC_SEQ;
    pc_sel      = npc;
    pc_we       = ~rst & (redirect | (~data_stall & ~id_hold));
    ifid_squash = ~rst & ctl.ifid;
    ifid_hold   = ~rst & data_stall & ~ctl.ifid;
    idex_squash = ~rst & (ctl.idex | data_stall);
    flush_count = rst ? '0 : fc;
    res_valid   = ~rst & resolve;
    res_bubbles = rst ? '0 : rb;
  end
endmodule

// File: rtl/bhc_ctrl_chk.sv
module bhc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] policy,
  input logic       if_valid,
  input logic       id_valid,
  input logic       ex_valid,
  input logic       id_is_ctrl,
  input logic       ex_is_ctrl,
  input logic       ex_taken,
  input logic       data_stall,
  input logic       pc_we,
  input logic       pc_sel,
  input logic       ifid_squash,
  input logic       ifid_hold,
  input logic       idex_squash,
  input logic [1:0] flush_count,
  input logic       res_valid,
  input logic [1:0] res_bubbles
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |-> (!pc_we && !pc_sel && !ifid_squash && !idex_squash && !ifid_hold));

  assert_target_writes_R3: assert property (@(posedge clk) disable iff (rst)
    pc_sel |-> pc_we);

  assert_slot_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'd0 && !data_stall) |-> !idex_squash);

  assert_stall_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (policy == 2'd1 && id_valid && id_is_ctrl && !(ex_valid && ex_is_ctrl && ex_taken))
      |-> !pc_we);

  assert_spec_flush_R6: assert property (@(posedge clk) disable iff (rst)
    (policy[1] && ex_valid && ex_is_ctrl && ex_taken && if_valid && id_valid)
      |-> (ifid_squash && idex_squash && flush_count == 2'd2));

  assert_squash_beats_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ifid_squash |-> !ifid_hold);

  assert_flush_range_R8: assert property (@(posedge clk) disable iff (rst)
    flush_count <= 2'd2);

  assert_idle_tally_R9: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (res_bubbles == 2'd0));

  assert_stall_carry_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && policy == 2'd1 && id_valid && id_is_ctrl && !data_stall && if_valid)
     && res_valid) |-> (res_bubbles >= 2'd1));
endmodule

bind bhc_ctrl bhc_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .policy      (policy),
  .if_valid    (if_valid),
  .id_valid    (id_valid),
  .ex_valid    (ex_valid),
  .id_is_ctrl  (id_is_ctrl),
  .ex_is_ctrl  (ex_is_ctrl),
  .ex_taken    (ex_taken),
  .data_stall  (data_stall),
  .pc_we       (pc_we),
  .pc_sel      (pc_sel),
  .ifid_squash (ifid_squash),
  .ifid_hold   (ifid_hold),
  .idex_squash (idex_squash),
  .flush_count (flush_count),
  .res_valid   (res_valid),
  .res_bubbles (res_bubbles)
);

// File: tb/tb_bhc_ctrl.sv
`timescale 1ns/1ps
module tb_bhc_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] policy = '0;
  logic       if_valid = 0, id_valid = 0, ex_valid = 0;
  logic       id_is_ctrl = 0, ex_is_ctrl = 0, ex_taken = 0, data_stall = 0;
  logic       pc_we, pc_sel, ifid_squash, ifid_hold, idex_squash, res_valid;
  logic [1:0] flush_count, res_bubbles;

  int checks = 0;
  int errors = 0;
  int exp_pend = 0;

  always #2.5 clk = ~clk;

  bhc_ctrl dut (
    .clk(clk), .rst(rst), .policy(policy),
    .if_valid(if_valid), .id_valid(id_valid), .ex_valid(ex_valid),
    .id_is_ctrl(id_is_ctrl), .ex_is_ctrl(ex_is_ctrl), .ex_taken(ex_taken),
    .data_stall(data_stall),
    .pc_we(pc_we), .pc_sel(pc_sel), .ifid_squash(ifid_squash),
    .ifid_hold(ifid_hold), .idex_squash(idex_squash),
    .flush_count(flush_count), .res_valid(res_valid), .res_bubbles(res_bubbles)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic drive(logic [8:0] v);
    {policy, if_valid, id_valid, ex_valid, id_is_ctrl, ex_is_ctrl, ex_taken, data_stall} = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset with an aggressive input pattern
    @(negedge clk);
    drive(9'b01_111_1111);
    #1;
    chk("R1 pc_we", pc_we, 0);
    chk("R1 pc_sel", pc_sel, 0);
    chk("R1 ifid_squash", ifid_squash, 0);
    chk("R1 idex_squash", idex_squash, 0);
    chk("R1 ifid_hold", ifid_hold, 0);
    chk("R1 flush_count", flush_count, 0);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 res_bubbles", res_bubbles, 0);
    @(negedge clk);
    rst = 1'b0;
    drive('0);
    exp_pend = 0;
    @(posedge clk);

    // R2..R9: exhaustive sweep; each vector also follows a new predecessor
    for (int v = 0; v < 512; v++) begin
      logic [1:0] p;
      logic ifv, idv, exv, idc, exc, tk, ds;
      logic redir, szh, spec, e_ifid, e_idex_ctl, e_idex, e_hold, e_we, zid;
      int e_fc, e_rb;
      @(negedge clk);
      drive(v[8:0]);
      {p, ifv, idv, exv, idc, exc, tk, ds} = v[8:0];
      redir      = exv & exc & tk;
      szh        = (p == 2'd1) & idv & idc;
      spec       = p[1];
      e_ifid     = ifv & (redir | (szh & ~ds));
      e_idex_ctl = spec & redir & idv;
      e_idex     = e_idex_ctl | ds;
      e_hold     = ds & ~e_ifid;
      e_we       = redir | (~ds & ~szh);
      zid        = szh & ~ds & ifv;
      e_fc       = int'(e_ifid) + int'(e_idex_ctl);
      e_rb       = (exv & exc) ? ((e_fc + exp_pend) % 4) : 0;
      #1;
      chk("R3 pc_sel", pc_sel, redir);
      chk("R5 R7 pc_we", pc_we, e_we);
      chk("R4 R5 R6 ifid_squash", ifid_squash, e_ifid);
      chk("R2 R6 R7 idex_squash", idex_squash, e_idex);
      chk("R7 ifid_hold", ifid_hold, e_hold);
      chk("R8 flush_count", flush_count, e_fc);
      chk("R9 res_valid", res_valid, exv & exc);
      chk("R9 res_bubbles", res_bubbles, e_rb);
      @(posedge clk);
      exp_pend = zid;
    end

    // R10: two-cycle streams, branch in ID then in EX
    for (int p = 0; p < 3; p++) begin
      for (int t = 0; t < 2; t++) begin
        int e_cost;
        @(negedge clk);
        drive('0);
        @(negedge clk);
        policy = 2'(p); if_valid = 1; id_valid = 1; ex_valid = 1;
        id_is_ctrl = 1; ex_is_ctrl = 0; ex_taken = 0; data_stall = 0;
        @(negedge clk);
        id_is_ctrl = 0; ex_is_ctrl = 1; ex_taken = t[0];
        id_valid = (p != 1);
        e_cost = (p == 0) ? t : ((p == 1) ? 1 + t : 2 * t);
        #1;
        chk("R10 res_valid", res_valid, 1);
        chk("R10 branch cost", res_bubbles, e_cost);
      end
    end

    @(negedge clk);
    drive('0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule